// File: doc/BRIEF.md
# Flash Block Lock Protection Unit

This unit guards the modify operations of a sixteen-block flash array. Each block carries its own lock bit, and one device-wide permanent lock bit sits above them. For every erase, word write or lock-configuration request it decides at once whether the operation may run. A granted operation holds the unit busy for a programmable number of cycles, which stands in for the nonvolatile write. A refused operation aborts and raises the status flags that a status register shows to software.

Two pin-level qualifiers can override protection. A high write-protect pin level lets an erase or word write reach a locked block. A high-voltage level on the reset pin overrides both block locks and the permanent lock. The permanent bit can never be cleared, and while it is set (with no high-voltage override) the block bits can be neither set nor cleared. Command parsing and the bus interface are handled elsewhere.

Top module: `flash_lock_guard`

## Requirements
- R1: After reset all block lock bits and the permanent bit are 0, busy, grant, abort and done are 0, and all three status flags are 0.
- R2: A request is accepted when `req_valid` is 1 and `busy` is 0. Kind codes: 0 erase, 1 word write, 2 set block lock, 3 set permanent lock, 4 clear all block locks. An erase or word write (kind 0 or 1) aimed at a block whose lock bit is 1, with `wp_n` 0 and `hv_reset` 0, gives a one-cycle `abort` on the cycle after acceptance and sets `sr_protect`. On an unlocked block it gives a one-cycle `grant` instead.
- R3: With `wp_n` 1 or `hv_reset` 1, an erase or word write to a locked block is granted.
- R4: Once `perm_lock` is 1 it stays 1 until reset, whatever requests follow.
- R5: A clear request while `perm_lock` is 1 and `hv_reset` is 0 aborts, sets `sr_protect` and `sr_clr_err`, and leaves the block lock bits unchanged. With `hv_reset` 1 it is granted.
- R6: A set-block request while `perm_lock` is 1 and `hv_reset` is 0 aborts and sets `sr_protect` and `sr_set_err`. A set-permanent request is always granted.
- R7: After a grant, `busy` is 1 for N cycles, where N is `busy_len` sampled at acceptance, or 1 when that value is 0. `done` pulses for one cycle together with the fall of `busy`, and any lock update becomes visible in that same cycle, never earlier and never after an abort.
- R8: A completed set-block request sets only the lock bit indexed by `req_block`. A completed clear request sets all sixteen block bits to 0 at once. A completed set-permanent request sets `perm_lock`.
- R9: A request presented while `busy` is 1 is ignored: no grant, no abort, no flag or lock change.
- R10: The three status flags are loaded on each accepted request of a known kind (all 0 on a grant) and otherwise hold their value.
- R11: Kind codes 5 to 7 are ignored: no grant, no abort, no busy, flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_kind | input | 3 | Operation kind code |
| req_block | input | 4 | Target block index |
| wp_n | input | 1 | Write-protect pin level (1 = block locks overridden for erase/write) |
| hv_reset | input | 1 | Reset pin held at high override voltage |
| busy_len | input | 8 | Modelled busy period in cycles (0 treated as 1) |
| grant | output | 1 | One-cycle pulse: request accepted and started |
| abort | output | 1 | One-cycle pulse: request refused by protection |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of the busy period |
| sr_protect | output | 1 | Device-protect status flag |
| sr_set_err | output | 1 | Lock-set failure status flag |
| sr_clr_err | output | 1 | Lock-clear failure status flag |
| lock_bits | output | 16 | Per-block lock bits |
| perm_lock | output | 1 | Permanent lock bit |

## Verification
The end of a busy period, which writes the lock bits, can fall in the same cycle as a new request that would read those bits for its protection decision. The bench provokes this by presenting requests on the last busy cycle and the cycle after, including a clear right behind a set-permanent and erases right behind a set-block on the same block. A behavioural reference model, compared on every clock, judges that the request in the last busy cycle is dropped and the one after sees the updated locks.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [2:0] {
    K_ERASE    = 3'd0,
    K_WRITE    = 3'd1,
    K_SET_BLK  = 3'd2,
    K_SET_PERM = 3'd3,
    K_CLR_ALL  = 3'd4
  } op_kind_e;

  function automatic logic kind_known(logic [2:0] k);
    return (k <= 3'd4);
  endfunction
endpackage

// File: rtl/flg_policy.sv
module flg_policy
  import flg_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BLKW = $clog2(NBLK)
) (
  input  logic [2:0]      kind,
  input  logic [BLKW-1:0] blk,
  input  logic [NBLK-1:0] locks,
  input  logic            perm,
  input  logic            wp_n,
  input  logic            hv_reset,
  output logic            known,
  output logic            allow,
  output logic            set_fail,
  output logic            clr_fail
);
  logic blk_locked;

  always_comb begin
    blk_locked = locks[blk];
    known      = kind_known(kind);
    case (kind)
      K_ERASE, K_WRITE: allow = !blk_locked || wp_n || hv_reset;
      K_SET_BLK:        allow = !perm || hv_reset;
      K_SET_PERM:       allow = 1'b1;
      K_CLR_ALL:        allow = !perm || hv_reset;
      default:          allow = 1'b0;
    endcase
    set_fail = known && !allow && (kind == K_SET_BLK);
    clr_fail = known && !allow && (kind == K_CLR_ALL);
  end
endmodule

// File: rtl/flg_busy_timer.sv
module flg_busy_timer #(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LENW-1:0] len,
  output logic            busy,
  output logic            fin
);
  logic [LENW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d;
  logic            cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fin    = busy_q && (cnt_q == '0);
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (fin) busy_d = 1'b0;
      else     cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      cnt_en = 1'b1;
      busy_d = 1'b1;
      cnt_d  = (len == '0) ? '0 : len - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  a_r7_fin_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);
endmodule

// File: rtl/flg_lock_store.sv
module flg_lock_store
  import flg_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BLKW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            apply,
  input  logic [2:0]      kind,
  input  logic [BLKW-1:0] blk,
  output logic [NBLK-1:0] locks,
  output logic            perm
);
  logic [NBLK-1:0] locks_q, locks_d;
  logic            perm_q, perm_d;

  always_comb begin
    locks_d = locks_q;
    perm_d  = perm_q;
    case (kind)
      K_SET_BLK:  locks_d[blk] = 1'b1;
      K_SET_PERM: perm_d       = 1'b1;
      K_CLR_ALL:  locks_d      = '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locks_q <= '0;
      perm_q  <= 1'b0;
    end else if (apply) begin
      locks_q <= locks_d;
      perm_q  <= perm_d;
    end
  end

  assign locks = locks_q;
  assign perm  = perm_q;

  a_r4_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);
  a_r7_no_update_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(locks_q) && $stable(perm_q)));
endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import flg_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int LENW = 8,
  localparam int BLKW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_kind,
  input  logic [BLKW-1:0] req_block,
  input  logic            wp_n,
  input  logic            hv_reset,
  input  logic [LENW-1:0] busy_len,
  output logic            grant,
  output logic            abort,
  output logic            busy,
  output logic            done,
  output logic            sr_protect,
  output logic            sr_set_err,
  output logic            sr_clr_err,
  output logic [NBLK-1:0] lock_bits,
  output logic            perm_lock
);
  logic            accept, known, allow, set_fail, clr_fail, fin, start;
  logic            grant_q, abort_q, done_q;
  logic            prot_q, serr_q, cerr_q;
  logic            flag_en;
  logic [2:0]      pend_kind_q;
  logic [BLKW-1:0] pend_blk_q;

  flg_policy #(.NBLK(NBLK)) u_policy (
    .kind(req_kind), .blk(req_block), .locks(lock_bits), .perm(perm_lock),
    .wp_n(wp_n), .hv_reset(hv_reset), .known(known), .allow(allow),
    .set_fail(set_fail), .clr_fail(clr_fail)
  );

  always_comb begin
    accept  = req_valid && !busy;
    flag_en = accept && known;
    start   = flag_en && allow;
  end

  flg_busy_timer #(.LENW(LENW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .len(busy_len),
    .busy(busy), .fin(fin)
  );

  flg_lock_store #(.NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(fin), .kind(pend_kind_q),
    .blk(pend_blk_q), .locks(lock_bits), .perm(perm_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      grant_q <= start;
      abort_q <= flag_en && !allow;
      done_q  <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      serr_q <= 1'b0;
      cerr_q <= 1'b0;
    end else if (flag_en) begin
      prot_q <= !allow;
      serr_q <= set_fail;
      cerr_q <= clr_fail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_kind_q <= '0;
      pend_blk_q  <= '0;
    end else if (start) begin
      pend_kind_q <= req_kind;
      pend_blk_q  <= req_block;
    end
  end

  assign grant      = grant_q;
  assign abort      = abort_q;
  assign done       = done_q;
  assign sr_protect = prot_q;
  assign sr_set_err = serr_q;
  assign sr_clr_err = cerr_q;

  a_r2_grant_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_q && abort_q));
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> (!grant && !abort));
  a_r5_clear_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == 3'd4 && perm_lock && !hv_reset)
      |=> (abort && sr_clr_err && sr_protect && $stable(lock_bits)));
  a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind > 3'd4) |=> (!grant && !abort && $stable(sr_protect)));
endmodule

// File: tb/tb_flash_lock_guard.sv
module tb_flash_lock_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [3:0]  req_block;
  logic        wp_n, hv_reset;
  logic [7:0]  busy_len;
  logic        grant, abort, busy, done, sr_protect, sr_set_err, sr_clr_err, perm_lock;
  logic [15:0] lock_bits;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_lock_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_block(req_block), .wp_n(wp_n), .hv_reset(hv_reset), .busy_len(busy_len),
    .grant(grant), .abort(abort), .busy(busy), .done(done),
    .sr_protect(sr_protect), .sr_set_err(sr_set_err), .sr_clr_err(sr_clr_err),
    .lock_bits(lock_bits), .perm_lock(perm_lock)
  );

  // behavioural reference model
  bit [15:0] m_lock;
  bit m_perm, m_busy, m_grant, m_abort, m_done, m_prot, m_serr, m_cerr;
  int m_cnt, m_kind, m_blk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_perm = 0; m_busy = 0; m_grant = 0; m_abort = 0; m_done = 0;
      m_prot = 0; m_serr = 0; m_cerr = 0; m_cnt = 0; m_kind = 0; m_blk = 0;
    end else begin
      bit ok;
      int k;
      m_grant = 0; m_abort = 0; m_done = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          if (m_kind == 2) m_lock[m_blk] = 1;
          else if (m_kind == 3) m_perm = 1;
          else if (m_kind == 4) m_lock = 0;
        end else m_cnt--;
      end else if (req_valid && req_kind <= 4) begin
        k = int'(req_kind);
        if (k <= 1) ok = !m_lock[req_block] || wp_n || hv_reset;
        else if (k == 3) ok = 1;
        else ok = !m_perm || hv_reset;
        m_prot = !ok;
        m_serr = !ok && k == 2;
        m_cerr = !ok && k == 4;
        if (ok) begin
          m_grant = 1; m_busy = 1; m_kind = k; m_blk = int'(req_block);
          m_cnt = (busy_len == 0) ? 0 : int'(busy_len) - 1;
        end else m_abort = 1;
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(grant == m_grant && abort == m_abort, "R2 grant/abort", {grant, abort}, {m_grant, m_abort});
      chk(busy == m_busy && done == m_done, "R7 busy/done", {busy, done}, {m_busy, m_done});
      chk(lock_bits == m_lock, "R8 lock_bits", lock_bits, m_lock);
      chk(perm_lock == m_perm, "R4 perm_lock", perm_lock, m_perm);
      chk({sr_protect, sr_set_err, sr_clr_err} == {m_prot, m_serr, m_cerr}, "R10 flags",
          {sr_protect, sr_set_err, sr_clr_err}, {m_prot, m_serr, m_cerr});
    end
  end

  // present one request for one cycle; returns at the negedge where grant/abort show
  task automatic op(input int k, input int b, input bit wp, input bit hv);
    req_valid = 1; req_kind = 3'(k); req_block = 4'(b); wp_n = wp; hv_reset = hv;
    @(negedge clk);
    req_valid = 0; wp_n = 0; hv_reset = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_block = 0; wp_n = 0; hv_reset = 0;
    busy_len = 8'd3;
    repeat (3) @(negedge clk);
    chk(lock_bits == 0 && !perm_lock && !busy && !grant && !abort && !done, "R1 reset outputs",
        {lock_bits, perm_lock, busy}, 0);
    chk({sr_protect, sr_set_err, sr_clr_err} == 0, "R1 reset flags",
        {sr_protect, sr_set_err, sr_clr_err}, 0);
    rst_n = 1;
    @(negedge clk);

    op(1, 3, 0, 0);
    chk(grant && !abort, "R2 write unlocked granted", {grant, abort}, 2);
    wait_idle();
    op(2, 3, 0, 0);
    wait_idle();
    chk(lock_bits == 16'h0008, "R8 set block 3 only", lock_bits, 16'h0008);
    op(0, 3, 0, 0);
    chk(abort && sr_protect, "R2 erase locked aborts", {abort, sr_protect}, 3);
    op(1, 3, 1, 0);
    chk(grant && !sr_protect, "R3 wp_n override", {grant, sr_protect}, 2);
    wait_idle();
    op(0, 3, 0, 1);
    chk(grant, "R3 hv_reset override", grant, 1);
    wait_idle();

    // busy length 0 treated as 1; back-to-back requests on the final busy cycle
    busy_len = 0;
    op(2, 15, 0, 0);
    chk(busy, "R7 len0 one cycle busy", busy, 1);
    req_valid = 1; req_kind = 3'd0; req_block = 4'd15;
    @(negedge clk);
    chk(!grant && !abort && done, "R9 request in last busy cycle ignored", {grant, abort, done}, 1);
    @(negedge clk);
    req_valid = 0;
    chk(abort && sr_protect, "R2 next request sees new lock", {abort, sr_protect}, 3);

    busy_len = 8'd4;
    op(2, 1, 0, 0);
    op(4, 0, 0, 0);
    chk(!grant && !abort, "R9 clear while busy ignored", {grant, abort}, 0);
    wait_idle();
    chk(lock_bits == 16'h800A, "R9 bits kept after ignored clear", lock_bits, 16'h800A);
    op(4, 0, 0, 0);
    chk(lock_bits == 16'h800A, "R7 no update before done", lock_bits, 16'h800A);
    wait_idle();
    chk(lock_bits == 0, "R8 clear all", lock_bits, 0);

    busy_len = 8'd2;
    op(2, 2, 0, 0); wait_idle();
    op(3, 0, 0, 0); wait_idle();
    chk(perm_lock, "R6 set permanent granted", perm_lock, 1);
    op(4, 0, 1, 0);
    chk(abort && sr_clr_err && sr_protect && !sr_set_err, "R5 clear refused",
        {abort, sr_clr_err, sr_protect, sr_set_err}, 4'hE);
    chk(lock_bits == 16'h0004, "R5 bits unchanged", lock_bits, 16'h0004);
    op(2, 4, 1, 0);
    chk(abort && sr_set_err && !sr_clr_err, "R6 set refused", {abort, sr_set_err, sr_clr_err}, 6);
    op(6, 4, 0, 0);
    chk(!grant && !abort && !busy && sr_set_err, "R11 unknown kind ignored",
        {grant, abort, busy, sr_set_err}, 1);
    op(4, 0, 0, 1); wait_idle();
    chk(lock_bits == 0 && perm_lock, "R4 perm survives clear", {lock_bits, perm_lock}, 1);
    op(2, 4, 0, 1); wait_idle();
    chk(lock_bits == 16'h0010, "R6 hv override set", lock_bits, 16'h0010);

    // random traffic, judged by the model every clock
    rst_n = 0; @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3000; i++) begin
      req_valid = ($urandom_range(0, 2) != 0);
      req_kind  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      req_block = 4'($urandom_range(0, 15));
      wp_n      = ($urandom_range(0, 3) == 0);
      hv_reset  = ($urandom_range(0, 5) == 0);
      busy_len  = 8'($urandom_range(0, 3));
      @(negedge clk);
    end
    req_valid = 0;
    repeat (5) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule